// File: doc/BRIEF.md
# Driver Protection Restart Sequencer

This block supervises the power stage of a two-winding step-motor driver. It merges a standby request with the digital undervoltage and overtemperature flags and the result of a ground-fault comparator. From these it produces one signal that permits the bridges to drive, one that returns the step indexer to its default position, and one that reports a latched ground fault.

Whenever a protection condition clears, the bridges are not released at once. The sequencer first waits a fixed number of cycles so the charge pump can recover. It then opens a short window in which the ground-fault comparator is sampled. Only if that window passes cleanly does it enter the running phase. A fault seen in the window is held until standby is asserted or the supply collapses (undervoltage). A protection event that arrives before running restarts the whole sequence. Both intervals are parameters counted in clock cycles.

Top module: `psq_restart_seq`

## Requirements
- R1: While any of `standby_i`, `uvlo_i` or `ovt_i` is 1 (all active high), `drive_permit_o` is 0 and `pos_reset_o` is 1 in that same cycle.
- R2: After the last protection input returns to 0 (or after reset is released), the sequencer stays in a settle phase of exactly SETTLE_CYC cycles, during which `drive_permit_o` is 0.
- R3: A probe window of exactly PROBE_CYC cycles follows the settle phase. If `gnd_fault_i` is 1 at any clock edge inside it, `fault_latched_o` becomes 1 after that edge and `drive_permit_o` stays 0.
- R4: With no fault and `out_disable_i` at 0, `drive_permit_o` first reads 1 after clock edge SETTLE_CYC+PROBE_CYC+1, counted from the first edge that sees all protection inputs at 0.
- R5: `out_disable_i` = 1 forces `drive_permit_o` to 0 in the same cycle. It neither stalls nor restarts the sequence, so permit returns in the same cycle the input drops if the running phase was reached.
- R6: A protection input that becomes 1 during the settle or probe phase sends the sequencer back to its off state, and the full settle and probe intervals run again after it clears.
- R7: Once set, `fault_latched_o` holds through `out_disable_i` and `ovt_i` activity. Only `standby_i` or `uvlo_i` clears it, one edge after it is sampled, and the full sequence then runs again.
- R8: `gnd_fault_i` has no effect outside the probe window: during settle or running it neither sets the latch nor drops the permit.
- R9: Synchronous reset drives `drive_permit_o` and `fault_latched_o` to 0 and starts the sequence from the off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| standby_i | input | 1 | Standby request, active high |
| uvlo_i | input | 1 | Debounced undervoltage flag, active high |
| ovt_i | input | 1 | Overtemperature flag, active high |
| out_disable_i | input | 1 | Output disable, 1 forces bridges off |
| gnd_fault_i | input | 1 | Ground-fault comparator result, 1 = fault |
| drive_permit_o | output | 1 | 1 = bridges may be driven |
| pos_reset_o | output | 1 | 1 = return step indexer to default position |
| fault_latched_o | output | 1 | 1 = ground fault latched |

## Verification
A phase register or interval counter that is off by one shows up at the ports as a permit edge that comes one or more cycles early or late. The bench therefore measures the release-to-permit distance exactly, in every scenario. A wrong window boundary shows up as a fault pulse that latches one cycle outside the probe window, or is missed one cycle inside it. The bench sweeps a one-cycle fault pulse across every edge position from release to running, and a protection glitch across every settle and probe cycle. Any such error becomes visible within one settle-plus-probe period.

// File: rtl/psq_pkg.sv
`timescale 1ns/1ps
package psq_pkg;

    typedef enum logic [2:0] {
        PH_HOLD,
        PH_SETTLE,
        PH_PROBE,
        PH_RUN,
        PH_TRIPPED
    } phase_e;

    typedef struct packed {
        logic standby;
        logic uvlo;
        logic ovt;
    } prot_flags_t;

    // bits needed to hold the value n
    function automatic int unsigned bits_for(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psq_prot_merge.sv
`timescale 1ns/1ps
module psq_prot_merge
    import psq_pkg::*;
(
    input  prot_flags_t flags,
    output logic        any_trip,
    output logic        latch_clear
);
    always_comb begin
        any_trip    = flags.standby | flags.uvlo | flags.ovt;
        // standby or collapsing supply are the only ways out of a latched fault
        latch_clear = flags.standby | flags.uvlo;
    end
endmodule

// File: rtl/psq_interval_timer.sv
`timescale 1ns/1ps
module psq_interval_timer #(
    parameter int unsigned LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [LW-1:0] limit,
    output logic          expired
);
    logic [LW-1:0] cnt_q;

    assign expired = (cnt_q == limit - LW'(1));

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + LW'(1);
    end
endmodule

// File: rtl/psq_restart_seq.sv
`timescale 1ns/1ps
module psq_restart_seq
    import psq_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 28000,
    parameter int unsigned PROBE_CYC  = 1100
) (
    input  logic clk,
    input  logic rst,
    input  logic standby_i,
    input  logic uvlo_i,
    input  logic ovt_i,
    input  logic out_disable_i,
    input  logic gnd_fault_i,
    output logic drive_permit_o,
    output logic pos_reset_o,
    output logic fault_latched_o
);
    localparam int unsigned LW = bits_for(max2(SETTLE_CYC, PROBE_CYC));
    localparam logic [LW-1:0] SETTLE_LIM = LW'(SETTLE_CYC);
    localparam logic [LW-1:0] PROBE_LIM  = LW'(PROBE_CYC);

    phase_e      ph_q, ph_d;
    prot_flags_t flags;
    logic        trip, clr, expired, restart;
    logic [LW-1:0] limit;

    assign flags = '{standby: standby_i, uvlo: uvlo_i, ovt: ovt_i};

    psq_prot_merge u_merge (
        .flags      (flags),
        .any_trip   (trip),
        .latch_clear(clr)
    );

    assign limit   = (ph_q == PH_PROBE) ? PROBE_LIM : SETTLE_LIM;
    assign restart = (ph_d != ph_q);

    psq_interval_timer #(.LW(LW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .limit  (limit),
        .expired(expired)
    );

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_HOLD:    if (!trip) ph_d = PH_SETTLE;
            PH_SETTLE:  if (trip) ph_d = PH_HOLD;
                        else if (expired) ph_d = PH_PROBE;
            PH_PROBE:   if (trip) ph_d = PH_HOLD;
                        else if (gnd_fault_i) ph_d = PH_TRIPPED;
                        else if (expired) ph_d = PH_RUN;
            PH_RUN:     if (trip) ph_d = PH_HOLD;
            PH_TRIPPED: if (clr) ph_d = PH_HOLD;
            default:    ph_d = PH_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_HOLD;
        else     ph_q <= ph_d;
    end

    assign drive_permit_o  = (ph_q == PH_RUN) && !trip && !out_disable_i;
    assign pos_reset_o     = trip;
    assign fault_latched_o = (ph_q == PH_TRIPPED);
endmodule

// File: rtl/psq_restart_seq_chk.sv
`timescale 1ns/1ps
module psq_restart_seq_chk (
    input logic clk,
    input logic rst,
    input logic standby_i,
    input logic uvlo_i,
    input logic ovt_i,
    input logic out_disable_i,
    input logic gnd_fault_i,
    input logic drive_permit_o,
    input logic pos_reset_o,
    input logic fault_latched_o
);
    a_r2_hold_after_release: assert property (@(posedge clk) disable iff (rst)
        ($past(standby_i | uvlo_i | ovt_i) && !(standby_i | uvlo_i | ovt_i)) |=> !drive_permit_o);

    a_r3_fault_from_probe: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_latched_o) |-> $past(gnd_fault_i));

    a_r3_fault_blocks_drive: assert property (@(posedge clk) disable iff (rst)
        fault_latched_o |-> !drive_permit_o);

    a_r5_disable_blocks: assert property (@(posedge clk) disable iff (rst)
        drive_permit_o |-> !out_disable_i);

    a_r1_reset_blocks_drive: assert property (@(posedge clk) disable iff (rst)
        pos_reset_o |-> !drive_permit_o);

    a_r7_latch_sticky: assert property (@(posedge clk) disable iff (rst)
        (fault_latched_o && !standby_i && !uvlo_i) |=> fault_latched_o);

    a_r7_latch_clears: assert property (@(posedge clk) disable iff (rst)
        (fault_latched_o && (standby_i || uvlo_i)) |=> !fault_latched_o);
endmodule

bind psq_restart_seq psq_restart_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .standby_i      (standby_i),
    .uvlo_i         (uvlo_i),
    .ovt_i          (ovt_i),
    .out_disable_i  (out_disable_i),
    .gnd_fault_i    (gnd_fault_i),
    .drive_permit_o (drive_permit_o),
    .pos_reset_o    (pos_reset_o),
    .fault_latched_o(fault_latched_o)
);

// File: tb/psq_restart_seq_bench.sv
`timescale 1ns/1ps
module psq_restart_seq_bench;
    localparam int S = 12;
    localparam int C = 4;
    localparam int E = S + C + 1;

    logic clk = 1'b0;
    logic rst, standby, uvlo, ovt, dis, gf;
    logic permit, posrst, fault;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #2.5 clk = ~clk;

    psq_restart_seq #(.SETTLE_CYC(S), .PROBE_CYC(C)) u_psq_restart_seq (
        .clk            (clk),
        .rst            (rst),
        .standby_i      (standby),
        .uvlo_i         (uvlo),
        .ovt_i          (ovt),
        .out_disable_i  (dis),
        .gnd_fault_i    (gf),
        .drive_permit_o (permit),
        .pos_reset_o    (posrst),
        .fault_latched_o(fault)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts clock edges until permit reads 1; 99 if it never does
    task automatic wait_permit(output int n);
        n = 0;
        while (n < 64) begin
            @(negedge clk);
            n++;
            if (permit) break;
        end
        if (!permit) n = 99;
    endtask

    task automatic enter_hold();
        @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int n;
        rst = 1; standby = 0; uvlo = 0; ovt = 0; dis = 0; gf = 0;
        repeat (3) @(negedge clk);
        check(permit == 0, "R9 permit in reset", permit, 0);
        check(fault == 0, "R9 fault in reset", fault, 0);
        rst = 0;
        wait_permit(n);
        check(n == E, "R9 R4 edges from reset to permit", n, E);

        // R1: each protection input blocks drive at once
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            standby = (i == 0); uvlo = (i == 1); ovt = (i == 2);
            #1;
            check(permit == 0, "R1 permit with protection", permit, 0);
            check(posrst == 1, "R1 pos reset with protection", posrst, 1);
            @(negedge clk);
            standby = 0; uvlo = 0; ovt = 0;
            wait_permit(n);
            check(n == E, "R2 R4 edges from release to permit", n, E);
        end

        // R5: disable in running, then disable through a whole sequence
        @(negedge clk); dis = 1; #1;
        check(permit == 0, "R5 disable drops permit", permit, 0);
        @(negedge clk); dis = 0; #1;
        check(permit == 1, "R5 permit returns", permit, 1);
        enter_hold();
        dis = 1; standby = 0;
        repeat (E + 3) @(negedge clk);
        check(permit == 0, "R5 permit held off by disable", permit, 0);
        dis = 0; #1;
        check(permit == 1, "R5 permit when disable drops", permit, 1);

        // R6: protection glitch at every settle/probe cycle restarts sequence
        for (int t = 1; t <= S + C; t++) begin
            enter_hold();
            standby = 0;
            repeat (t) @(negedge clk);
            check(permit == 0, "R2 permit before interval ends", permit, 0);
            ovt = 1;
            @(negedge clk);
            ovt = 0;
            wait_permit(n);
            check(n == E, "R6 restart after glitch", n, E);
        end

        // R3/R8: fault pulse swept over every edge from release to running
        for (int e = 1; e <= S + C + 3; e++) begin
            bit exp_f;
            exp_f = (e >= S + 2) && (e <= S + C + 1);
            enter_hold();
            standby = 0;
            repeat (e - 1) @(negedge clk);
            gf = 1;
            @(negedge clk);
            gf = 0;
            repeat (E + 2 - e) @(negedge clk);
            check(fault == exp_f, exp_f ? "R3 fault in probe window" : "R8 fault ignored outside window", fault, exp_f);
            check(permit == !exp_f, exp_f ? "R3 permit blocked by fault" : "R8 permit kept", permit, !exp_f);
            @(negedge clk); standby = 1; @(negedge clk);
            check(fault == 0, "R7 standby clears latch", fault, 0);
        end

        // R7: latch survives disable and overtemperature, cleared by undervoltage
        enter_hold();
        standby = 0;
        repeat (S + 2) @(negedge clk);
        gf = 1; @(negedge clk); gf = 0;
        check(fault == 1, "R3 latch set", fault, 1);
        dis = 1; ovt = 1;
        repeat (4) @(negedge clk);
        dis = 0; ovt = 0;
        repeat (E + 3) @(negedge clk);
        check(fault == 1, "R7 latch survives disable and ovt", fault, 1);
        check(permit == 0, "R7 no permit while latched", permit, 0);
        uvlo = 1; @(negedge clk);
        check(fault == 0, "R7 undervoltage clears latch", fault, 0);
        uvlo = 0;
        wait_permit(n);
        check(n == E, "R7 full sequence after clear", n, E);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule